// File: doc/BRIEF.md
# ATM Receive Cell Validator and Formatter

This block sits between cell delineation and a receive FIFO. It takes delineated 53-octet cells, one octet per valid cycle, marked with a start-of-cell strobe and tagged with the output port the cell is addressed to. For every cell it checks the 8-bit header check code. Depending on its settings, it repairs a single flipped bit in the 40 header bits. It then emits the cell in the octet layout that the destination port has chosen.

Each of the four output ports picks one of four lengths. The last port can also take two extra options. The first is a five-octet header-only summary. The second is a 53-octet layout in which the check octet is dropped and a status octet is appended at the end. The status octet reports header error results, the match results of the other three ports' address lookups (supplied as input flags), and a user-data indication decoded from the payload-type field. The block stores whole cells in a two-bank RAM so that it can reorder them into these layouts.

Top module: `atm_cell_formatter`

## Requirements
- R1: The port's 2-bit format code selects the output layout. Code 0 gives the 48 payload octets only. Code 1 gives the 4 header octets then the payload (52). Code 2 gives the 4 header octets, the check octet, then the payload (53). Code 3 gives four PAD_OCTET fill octets followed by the code-2 layout (57).
- R2: out_sop is high on the first octet of every output cell only. out_valid is high for each octet of a cell on consecutive cycles. out_port carries the port the cell was tagged with. Every accepted cell is emitted.
- R3: The expected check octet is the CRC-8 of the covered header octets (polynomial x^8+x^2+x+1, zero start, most significant bit first), XORed with 0x55 when coset_en is high. All four header octets are covered, or only the last three when short_cov is high.
- R4: When corr_en and coset_en are high and short_cov is low, a single flipped bit anywhere in the 32 header bits or the 8 check bits is repaired in the emitted header and check octets. The repair also sets status bit 5.
- R5: When corr_en is low, coset_en is low, or short_cov is high, no repair takes place. The header and check octets are emitted exactly as received. Any mismatch is still detected.
- R6: A mismatch that is not repaired (several flipped bits, or repair off) sets status bit 6, and the cell is still emitted in full.
- R7: With hdr_only high, a cell tagged for port 3 is emitted as its 4 header octets followed by the status octet (5 octets). This takes priority over stat_en.
- R8: With stat_en high and hdr_only low, a cell tagged for port 3 whose format code is 2 is emitted as the 4 header octets, the 48 payload octets and the status octet (53). The check octet is omitted.
- R9: Status octet fields: bit 7 is the user-data bit; bit 6 is uncorrectable; bit 5 is repaired; bits 4:3 are zero; bit i (i = 0..2) is match_hit[i] AND match_en[i]. Bits 6 and 5 are set only when flag_en is high. The match flags are sampled with the cell's fifth input octet.
- R10: The payload type is bits 3:1 of the fourth (repaired) header octet. The user-data bit equals payload-type bit 0 when payload-type bit 2 is 0, and is 0 otherwise.
- R11: hdr_only and stat_en have no effect while any port has format code 3, and none on cells tagged for ports 0 to 2.
- R12: After reset, out_valid and out_sop stay low until a complete cell has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input octet valid |
| in_sop | input | 1 | First octet of a 53-octet cell |
| in_data | input | 8 | Input octet |
| in_port | input | 2 | Destination port of the cell, sampled with in_sop |
| port_fmt | input | 8 | Format code per port, port p in bits 2p+1:2p |
| corr_en | input | 1 | Single-bit header repair request |
| coset_en | input | 1 | Check octet carries the 0x55 coset |
| short_cov | input | 1 | Check covers only the last three header octets |
| hdr_only | input | 1 | Port-3 header-only layout |
| stat_en | input | 1 | Port-3 trailing status octet layout |
| flag_en | input | 1 | Enables the header error bits in the status octet |
| match_hit | input | 3 | Address match results of ports 0..2 |
| match_en | input | 3 | Enables each match flag in the status octet |
| out_valid | output | 1 | Output octet valid |
| out_sop | output | 1 | First octet of an output cell |
| out_data | output | 8 | Output octet |
| out_port | output | 2 | Port of the cell being emitted |

## Verification
On every cycle the assertions check three things. A start strobe never appears without a valid octet. A start is always followed by another octet of the same cell. Each completed output cell has one of the five legal lengths. They also check that the repair logic stays idle whenever the repair conditions of R5 are not all met. Correct octet order, correct repaired bit, status bit values, the user-data decode and the suppression of the port-3 options by a 57-octet port can only be shown by the bench. It does so by comparing every emitted octet with a reference that searches all 40 single-bit flips, across directed error patterns and randomised settings.

// File: rtl/atm_fmt_pkg.sv
package atm_fmt_pkg;
  localparam int HDR_OCT  = 4;
  localparam int PAY_OCT  = 48;
  localparam int CELL_OCT = 53;
  localparam int PAD_CNT  = 4;

  typedef enum logic [1:0] {
    FMT_PAY   = 2'd0,
    FMT_NOHEC = 2'd1,
    FMT_FULL  = 2'd2,
    FMT_PAD   = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    PL_PAY, PL_NOHEC, PL_FULL, PL_PAD, PL_HDRONLY, PL_STAT
  } plan_e;

  typedef enum logic [2:0] {
    SRC_PAD, SRC_HDR, SRC_HEC, SRC_PAY, SRC_STAT
  } src_e;

  typedef struct packed {
    logic [31:0] hdr;
    logic [7:0]  hec;
    logic [7:0]  stat;
    plan_e       plan;
  } desc_t;

  // CRC-8, x^8+x^2+x+1, zero start, MSB first over 32 bits
  function automatic logic [7:0] crc8_32(input logic [31:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [5:0] plan_len(input plan_e p);
    case (p)
      PL_PAY:     return 6'd48;
      PL_NOHEC:   return 6'd52;
      PL_PAD:     return 6'd57;
      PL_HDRONLY: return 6'd5;
      default:    return 6'd53;
    endcase
  endfunction
endpackage

// File: rtl/atm_hec_unit.sv
module atm_hec_unit
  import atm_fmt_pkg::*;
#(
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic [31:0] hdr_i,
  input  logic [7:0]  hec_i,
  input  logic        short_cov_i,
  input  logic        coset_en_i,
  input  logic        corr_allow_i,
  output logic [31:0] hdr_o,
  output logic [7:0]  hec_o,
  output logic        fixed_o,
  output logic        uncorr_o
);
  localparam int NBIT = 40;

  logic [31:0]     cov;
  logic [7:0]      syn;
  logic [NBIT-1:0] hit;
  logic [NBIT-1:0] word;

  assign cov = short_cov_i ? {8'h00, hdr_i[23:0]} : hdr_i;
  assign syn = crc8_32(cov) ^ (coset_en_i ? COSET : 8'h00) ^ hec_i;

  // one comparator per single-bit error position
  for (genvar k = 0; k < 8; k++) begin : g_hec_bit
    assign hit[k] = (syn == (8'd1 << k));
  end
  for (genvar j = 0; j < 32; j++) begin : g_hdr_bit
    localparam logic [7:0] SYN_J = crc8_32(32'd1 << j);
    assign hit[8+j] = (syn == SYN_J);
  end

  assign fixed_o  = corr_allow_i && (|hit);
  assign uncorr_o = (syn != 8'h00) && !fixed_o;
  assign word     = {hdr_i, hec_i} ^ (fixed_o ? hit : '0);
  assign hdr_o    = word[39:8];
  assign hec_o    = word[7:0];
endmodule

// File: rtl/atm_cell_store.sv
module atm_cell_store
  import atm_fmt_pkg::*;
#(
  parameter int          NPORT     = 4,
  parameter int          PW        = 2,
  parameter int          NMATCH    = 3,
  parameter int          NBANK     = 2,
  parameter int          STAT_PORT = 3,
  parameter logic [7:0]  COSET     = 8'h55,
  localparam int         BW        = $clog2(NBANK),
  localparam int         AW        = $clog2(PAY_OCT),
  localparam int         RAW       = BW + AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic [7:0]           in_data,
  input  logic [PW-1:0]        in_port,
  input  logic [2*NPORT-1:0]   port_fmt,
  input  logic                 corr_en,
  input  logic                 coset_en,
  input  logic                 short_cov,
  input  logic                 hdr_only,
  input  logic                 stat_en,
  input  logic                 flag_en,
  input  logic [NMATCH-1:0]    match_hit,
  input  logic [NMATCH-1:0]    match_en,
  input  logic [RAW-1:0]       rd_addr,
  output logic [7:0]           rd_data,
  input  logic                 rel_valid,
  input  logic [BW-1:0]        rel_bank,
  output logic [NBANK-1:0]     bank_full,
  output desc_t                bank_desc [NBANK],
  output logic [PW-1:0]        bank_port [NBANK],
  output logic                 hec_fixed
);
  localparam int IW = $clog2(CELL_OCT);

  logic            active;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   pidx;
  logic [BW-1:0]   wr_bank;
  logic [31:0]     hdr_sr;
  logic [PW-1:0]   port_q;
  logic            hec_stage, pay_we;
  logic [31:0]     fix_hdr;
  logic [7:0]      fix_hec;
  logic            hec_uncorr;
  logic            corr_allow;
  logic            any_pad;
  fmt_e            cell_fmt;
  plan_e           plan;
  logic            opt_ok;
  logic [7:0]      stat;
  desc_t           new_desc;
  logic [7:0]      mem [NBANK << AW];

  assign corr_allow = corr_en && coset_en && !short_cov;
  assign hec_stage  = in_valid && active && !in_sop && (idx == IW'(HDR_OCT));
  assign pay_we     = in_valid && active && !in_sop && (idx > IW'(HDR_OCT));
  assign pidx       = idx - IW'(HDR_OCT + 1);

  atm_hec_unit #(.COSET(COSET)) u_hec (
    .hdr_i        (hdr_sr),
    .hec_i        (in_data),
    .short_cov_i  (short_cov),
    .coset_en_i   (coset_en),
    .corr_allow_i (corr_allow),
    .hdr_o        (fix_hdr),
    .hec_o        (fix_hec),
    .fixed_o      (hec_fixed),
    .uncorr_o     (hec_uncorr)
  );

  always_comb begin
    any_pad = 1'b0;
    for (int p = 0; p < NPORT; p++)
      if (port_fmt[2*p +: 2] == FMT_PAD) any_pad = 1'b1;
  end

  assign cell_fmt = fmt_e'(port_fmt[2*port_q +: 2]);
  assign opt_ok   = !any_pad && (port_q == PW'(STAT_PORT));

  always_comb begin
    if (opt_ok && hdr_only)                          plan = PL_HDRONLY;
    else if (opt_ok && stat_en && cell_fmt == FMT_FULL) plan = PL_STAT;
    else begin
      case (cell_fmt)
        FMT_PAY:   plan = PL_PAY;
        FMT_NOHEC: plan = PL_NOHEC;
        FMT_FULL:  plan = PL_FULL;
        default:   plan = PL_PAD;
      endcase
    end
  end

  assign stat = {(!fix_hdr[3] && fix_hdr[1]),
                 (flag_en && hec_uncorr),
                 (flag_en && hec_fixed),
                 5'(match_hit & match_en)};

  always_comb begin
    new_desc.hdr  = fix_hdr;
    new_desc.hec  = fix_hec;
    new_desc.stat = stat;
    new_desc.plan = plan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      idx       <= '0;
      wr_bank   <= '0;
      bank_full <= '0;
    end else begin
      if (rel_valid) bank_full[rel_bank] <= 1'b0;
      if (in_valid && in_sop) begin
        active <= 1'b1;
        idx    <= IW'(1);
      end else if (in_valid && active) begin
        idx <= idx + 1'b1;
        if (idx == IW'(CELL_OCT - 1)) begin
          active             <= 1'b0;
          bank_full[wr_bank] <= 1'b1;
          wr_bank            <= (wr_bank == BW'(NBANK - 1)) ? '0 : wr_bank + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_sop) begin
      hdr_sr <= {hdr_sr[23:0], in_data};
      port_q <= in_port;
    end else if (in_valid && active && idx < IW'(HDR_OCT)) begin
      hdr_sr <= {hdr_sr[23:0], in_data};
    end
    if (hec_stage) begin
      bank_desc[wr_bank] <= new_desc;
      bank_port[wr_bank] <= port_q;
    end
  end

  // payload RAM, one write and one registered read port
  always_ff @(posedge clk) begin
    if (pay_we) mem[{wr_bank, pidx[AW-1:0]}] <= in_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/atm_out_seq.sv
module atm_out_seq
  import atm_fmt_pkg::*;
#(
  parameter int         NBANK     = 2,
  parameter int         PW        = 2,
  parameter logic [7:0] PAD_OCTET = 8'h00,
  localparam int        BW        = $clog2(NBANK),
  localparam int        AW        = $clog2(PAY_OCT),
  localparam int        RAW       = BW + AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NBANK-1:0]   bank_full,
  input  desc_t              bank_desc [NBANK],
  input  logic [PW-1:0]      bank_port [NBANK],
  input  logic [7:0]         rd_data,
  output logic [RAW-1:0]     rd_addr,
  output logic               rel_valid,
  output logic [BW-1:0]      rel_bank,
  output logic               out_valid,
  output logic               out_sop,
  output logic [7:0]         out_data,
  output logic [PW-1:0]      out_port
);
  logic          busy;
  logic [BW-1:0] rd_bank;
  logic [5:0]    k;
  logic [5:0]    len;
  desc_t         cur;
  logic [PW-1:0] cur_port;
  src_e          src;
  logic [1:0]    hsel;
  logic [5:0]    paddr;
  logic [31:0]   hshift;
  logic [7:0]    oct;
  logic          s_vld, s_sop, s_pay;
  logic [7:0]    s_oct;
  logic [PW-1:0] s_port;

  always_comb begin
    src   = SRC_PAD;
    hsel  = k[1:0];
    paddr = k;
    case (cur.plan)
      PL_PAY: src = SRC_PAY;
      PL_NOHEC: begin
        src   = (k < 6'd4) ? SRC_HDR : SRC_PAY;
        paddr = k - 6'd4;
      end
      PL_FULL: begin
        src   = (k < 6'd4) ? SRC_HDR : (k == 6'd4) ? SRC_HEC : SRC_PAY;
        paddr = k - 6'd5;
      end
      PL_PAD: begin
        src   = (k < 6'd4) ? SRC_PAD : (k < 6'd8) ? SRC_HDR :
                (k == 6'd8) ? SRC_HEC : SRC_PAY;
        paddr = k - 6'd9;
      end
      PL_HDRONLY: src = (k < 6'd4) ? SRC_HDR : SRC_STAT;
      PL_STAT: begin
        src   = (k < 6'd4) ? SRC_HDR : (k < 6'd52) ? SRC_PAY : SRC_STAT;
        paddr = k - 6'd4;
      end
      default: src = SRC_PAD;
    endcase
  end

  assign hshift = cur.hdr >> {~hsel, 3'b000};

  always_comb begin
    case (src)
      SRC_HDR:  oct = hshift[7:0];
      SRC_HEC:  oct = cur.hec;
      SRC_STAT: oct = cur.stat;
      default:  oct = PAD_OCTET;
    endcase
  end

  assign rd_addr   = {rd_bank, paddr[AW-1:0]};
  assign rel_valid = busy && (k == len - 6'd1);
  assign rel_bank  = rd_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rd_bank   <= '0;
      k         <= '0;
      s_vld     <= 1'b0;
      s_sop     <= 1'b0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      s_vld <= busy;
      s_sop <= busy && (k == 6'd0);
      if (!busy && bank_full[rd_bank]) begin
        busy     <= 1'b1;
        k        <= '0;
        cur      <= bank_desc[rd_bank];
        cur_port <= bank_port[rd_bank];
        len      <= plan_len(bank_desc[rd_bank].plan);
      end else if (busy) begin
        k <= k + 6'd1;
        if (rel_valid) begin
          busy    <= 1'b0;
          rd_bank <= (rd_bank == BW'(NBANK - 1)) ? '0 : rd_bank + 1'b1;
        end
      end
      out_valid <= s_vld;
      out_sop   <= s_sop;
      out_data  <= s_pay ? rd_data : s_oct;
    end
  end

  always_ff @(posedge clk) begin
    s_pay    <= (src == SRC_PAY);
    s_oct    <= oct;
    s_port   <= cur_port;
    out_port <= s_port;
  end
endmodule

// File: rtl/atm_cell_formatter.sv
module atm_cell_formatter
  import atm_fmt_pkg::*;
#(
  parameter int         NPORT     = 4,
  parameter int         NBANK     = 2,
  parameter logic [7:0] PAD_OCTET = 8'h00,
  parameter logic [7:0] COSET     = 8'h55,
  localparam int        PW        = $clog2(NPORT),
  localparam int        NMATCH    = NPORT - 1,
  localparam int        BW        = $clog2(NBANK),
  localparam int        RAW       = BW + $clog2(PAY_OCT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic [7:0]          in_data,
  input  logic [PW-1:0]       in_port,
  input  logic [2*NPORT-1:0]  port_fmt,
  input  logic                corr_en,
  input  logic                coset_en,
  input  logic                short_cov,
  input  logic                hdr_only,
  input  logic                stat_en,
  input  logic                flag_en,
  input  logic [NMATCH-1:0]   match_hit,
  input  logic [NMATCH-1:0]   match_en,
  output logic                out_valid,
  output logic                out_sop,
  output logic [7:0]          out_data,
  output logic [PW-1:0]       out_port
);
  logic [RAW-1:0]   rd_addr;
  logic [7:0]       rd_data;
  logic             rel_valid;
  logic [BW-1:0]    rel_bank;
  logic [NBANK-1:0] bank_full;
  desc_t            bank_desc [NBANK];
  logic [PW-1:0]    bank_port [NBANK];
  logic             hec_fixed;

  atm_cell_store #(
    .NPORT(NPORT), .PW(PW), .NMATCH(NMATCH), .NBANK(NBANK),
    .STAT_PORT(NPORT - 1), .COSET(COSET)
  ) u_store (
    .clk, .rst, .in_valid, .in_sop, .in_data, .in_port, .port_fmt,
    .corr_en, .coset_en, .short_cov, .hdr_only, .stat_en, .flag_en,
    .match_hit, .match_en, .rd_addr, .rd_data, .rel_valid, .rel_bank,
    .bank_full, .bank_desc, .bank_port, .hec_fixed
  );

  atm_out_seq #(
    .NBANK(NBANK), .PW(PW), .PAD_OCTET(PAD_OCTET)
  ) u_seq (
    .clk, .rst, .bank_full, .bank_desc, .bank_port, .rd_data, .rd_addr,
    .rel_valid, .rel_bank, .out_valid, .out_sop, .out_data, .out_port
  );
endmodule

// File: rtl/atm_fmt_checker.sv
module atm_fmt_checker (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic out_sop,
  input logic corr_en,
  input logic coset_en,
  input logic short_cov,
  input logic hec_fixed
);
  logic [6:0] cnt;
  logic       seen;
  logic       len_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (out_valid) begin
      cnt  <= out_sop ? 7'd1 : cnt + 7'd1;
      seen <= 1'b1;
    end
  end

  assign len_ok = (cnt == 7'd5) || (cnt == 7'd48) || (cnt == 7'd52) ||
                  (cnt == 7'd53) || (cnt == 7'd57);

  assert_sop_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);

  assert_cell_continues_R2: assert property (@(posedge clk) disable iff (rst)
    out_sop |=> out_valid);

  assert_cell_length_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop && seen) |-> len_ok);

  assert_no_repair_R5: assert property (@(posedge clk) disable iff (rst)
    !(corr_en && coset_en && !short_cov) |-> !hec_fixed);

  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sop));
endmodule

bind atm_cell_formatter atm_fmt_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .corr_en   (corr_en),
  .coset_en  (coset_en),
  .short_cov (short_cov),
  .hec_fixed (hec_fixed)
);

// File: tb/sim_atm_cell_formatter.sv
module sim_atm_cell_formatter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_port = '0;
  logic [7:0] port_fmt = 8'hAA;
  logic       corr_en = 0, coset_en = 1, short_cov = 0;
  logic       hdr_only = 0, stat_en = 0, flag_en = 1;
  logic [2:0] match_hit = '0, match_en = 3'b111;
  logic       out_valid, out_sop;
  logic [7:0] out_data;
  logic [1:0] out_port;

  always #2 clk = ~clk;

  atm_cell_formatter u0 (
    .clk, .rst, .in_valid, .in_sop, .in_data, .in_port, .port_fmt,
    .corr_en, .coset_en, .short_cov, .hdr_only, .stat_en, .flag_en,
    .match_hit, .match_en, .out_valid, .out_sop, .out_data, .out_port
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] exp_d[$];
  bit         exp_s[$];
  bit         exp_l[$];
  logic [1:0] exp_p[$];
  string      exp_t[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 4; i++) begin
      c ^= h[31-8*i -: 8];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] covered(input logic [31:0] h);
    return short_cov ? {8'h00, h[23:0]} : h;
  endfunction

  // monitor: compares every emitted octet, one check per cell
  bit cbad = 0;
  int pos = 0, bad_pos = 0;
  int fa = 0, fe = 0;
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_d.size() == 0) begin
        chk(0, "R2", "octet with no cell expected", int'(out_data), 0);
      end else begin
        logic [7:0] ed; bit es, el; logic [1:0] ep; string et;
        ed = exp_d.pop_front(); es = exp_s.pop_front(); el = exp_l.pop_front();
        ep = exp_p.pop_front(); et = exp_t.pop_front();
        if (!cbad && (out_data !== ed || out_sop !== es || out_port !== ep)) begin
          cbad = 1; bad_pos = pos;
          fa = int'({out_sop, out_port, out_data});
          fe = int'({es, ep, ed});
        end
        pos++;
        if (el) begin
          chk(!cbad, et, $sformatf("cell octet %0d {sop,port,data}", bad_pos), fa, fe);
          cbad = 0; pos = 0;
        end
      end
    end
  end

  // builds the expected output and then drives one cell
  task automatic send_cell(input int nerr, input int ptv, input int prt, input string tag);
    logic [31:0] h; logic [7:0] hec, cv, syn; logic [39:0] w, t;
    logic [7:0] pay[48]; logic [7:0] seqo[$]; logic [7:0] st;
    logic [1:0] port; logic [2:0] hits; logic [1:0] f;
    bit fixed, uncorr, allow, any57, ok, user;
    int b1, b2;
    h = $urandom;
    if (ptv >= 0) h[3:1] = ptv[2:0];
    port = (prt >= 0) ? prt[1:0] : 2'($urandom % 4);
    hits = 3'($urandom % 8);
    for (int i = 0; i < 48; i++) pay[i] = 8'($urandom);
    cv  = coset_en ? 8'h55 : 8'h00;
    hec = ref_crc(covered(h)) ^ cv;
    w = {h, hec};
    if (nerr >= 1) begin b1 = $urandom % 40; w[b1] = ~w[b1]; end
    if (nerr >= 2) begin b2 = (b1 + 1 + ($urandom % 39)) % 40; w[b2] = ~w[b2]; end
    begin : drive_copy
      logic [39:0] tx = w;
      // reference decode
      syn = ref_crc(covered(w[39:8])) ^ cv ^ w[7:0];
      allow = corr_en && coset_en && !short_cov;
      fixed = 0;
      if (syn != 0 && allow)
        for (int b = 0; b < 40; b++) begin
          t = w ^ (40'd1 << b);
          if ((ref_crc(covered(t[39:8])) ^ cv) == t[7:0]) begin fixed = 1; w = t; end
        end
      uncorr = (syn != 0) && !fixed;
      user = !w[11] && w[9];
      st = {user, flag_en && uncorr, flag_en && fixed, 2'b00, hits & match_en};
      any57 = 0;
      for (int p = 0; p < 4; p++) if (port_fmt[2*p +: 2] == 2'd3) any57 = 1;
      ok = !any57 && port == 2'd3;
      f = port_fmt[2*port +: 2];
      if (ok && hdr_only) begin
        for (int i = 0; i < 4; i++) seqo.push_back(w[39-8*i -: 8]);
        seqo.push_back(st);
      end else if (ok && stat_en && f == 2'd2) begin
        for (int i = 0; i < 4; i++) seqo.push_back(w[39-8*i -: 8]);
        for (int i = 0; i < 48; i++) seqo.push_back(pay[i]);
        seqo.push_back(st);
      end else begin
        if (f == 2'd3) for (int i = 0; i < 4; i++) seqo.push_back(8'h00);
        if (f != 2'd0) for (int i = 0; i < 4; i++) seqo.push_back(w[39-8*i -: 8]);
        if (f >= 2'd2) seqo.push_back(w[7:0]);
        for (int i = 0; i < 48; i++) seqo.push_back(pay[i]);
      end
      foreach (seqo[i]) begin
        exp_d.push_back(seqo[i]); exp_s.push_back(i == 0);
        exp_l.push_back(i == seqo.size() - 1);
        exp_p.push_back(port); exp_t.push_back(tag);
      end
      for (int i = 0; i < 53; i++) begin
        @(negedge clk);
        in_valid  = 1; in_sop = (i == 0); in_port = port; match_hit = hits;
        in_data   = (i < 5) ? tx[39-8*i -: 8] : pay[i-5];
      end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (exp_d.size() != 0 && w < 400) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    chk(exp_d.size() == 0, tag, "octets still owed after drain", exp_d.size(), 0);
  endtask

  task automatic phase(input int ncell, input int nerr, input string tag);
    for (int i = 0; i < ncell; i++) send_cell(nerr, -1, -1, tag);
    drain(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    report();
  end

  initial begin
    bit idle_ok;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst = 0;
    idle_ok = 1;
    repeat (10) begin @(negedge clk); if (out_valid || out_sop) idle_ok = 0; end
    chk(idle_ok, "R12", "output idle after reset", int'(out_valid), 0);

    // R1 R3: full 53-octet layout, clean cells
    port_fmt = 8'hAA; corr_en = 0;
    phase(6, 0, "R1 R3");
    // R1 R2: one format per port, random ports
    port_fmt = {2'd3, 2'd2, 2'd1, 2'd0};
    phase(12, 0, "R1 R2");
    // R4 R8 R9: single-bit repair with status on port 3
    port_fmt = 8'hAA; corr_en = 1; stat_en = 1;
    phase(12, 1, "R4 R8 R9");
    for (int i = 0; i < 4; i++) send_cell(1, -1, 3, "R4 R8");
    drain("R4");
    // R5 R3: short coverage blocks repair
    short_cov = 1;
    phase(8, 1, "R5 R3");
    short_cov = 0; coset_en = 0;
    phase(6, 1, "R5");
    coset_en = 1; corr_en = 0;
    phase(6, 1, "R5 R6");
    // R6: two flipped bits are never repaired
    corr_en = 1;
    for (int i = 0; i < 8; i++) send_cell(2, -1, 3, "R6");
    drain("R6");
    // R9: header flags masked
    flag_en = 0; match_en = 3'b101;
    for (int i = 0; i < 6; i++) send_cell(i % 3, -1, 3, "R9");
    drain("R9");
    flag_en = 1; match_en = 3'b111;
    // R10: every payload type value
    for (int v = 0; v < 8; v++) send_cell(0, v, 3, "R10");
    drain("R10");
    // R7: header-only
    hdr_only = 1; port_fmt = {2'd2, 2'd1, 2'd0, 2'd2};
    phase(12, 1, "R7");
    for (int v = 0; v < 4; v++) send_cell(v % 3, v + 2, 3, "R7 R10");
    drain("R7");
    // R11: a 57-octet port suppresses both options
    port_fmt = {2'd2, 2'd2, 2'd2, 2'd3};
    for (int i = 0; i < 6; i++) send_cell(1, -1, 3, "R11");
    drain("R11");
    hdr_only = 0; port_fmt = 8'hAA;
    phase(8, 1, "R11 R8");
    // randomised settings
    for (int r = 0; r < 6; r++) begin
      port_fmt = 8'($urandom); corr_en = 1'($urandom); coset_en = 1'($urandom);
      short_cov = 1'($urandom); hdr_only = 1'($urandom); stat_en = 1'($urandom);
      flag_en = 1'($urandom); match_en = 3'($urandom);
      phase(10, r % 3, "R1 R4 R6 R8");
    end
    report();
  end
endmodule